// File: doc/BRIEF.md
# Retired-Instruction Countdown Trigger

This block is a single debug trigger that counts instructions down as the core retires them and asks for a breakpoint when the count runs out. Software programs it by writing one control word. That word holds a 14-bit remaining count and a set of privilege-mode enables. The core feeds the block a retire strobe each cycle, along with the current privilege level and a flag saying whether the hart runs virtualized.

The count is kept inside the control word itself and is decremented in place. A read of the control word therefore always shows how many enabled instructions are still to go. A count of zero means the trigger is idle. When an enabled retirement takes the count from one to zero, the block raises a single-cycle breakpoint request. The count then rests at zero until software writes a new value.

Control word layout, with every other bit reading as zero:

| Bits | Field |
|------|-------|
| 23:10 | remaining count |
| 6 | U enable |
| 7 | S enable |
| 9 | M enable |
| 25 | VU enable |
| 26 | VS enable |

Privilege encoding on `priv_i`: 0 = user, 1 = supervisor, 3 = machine, 2 = reserved.

Top module: `icnt_trigger`

## Requirements
- R1: After reset the control word reads zero and `fire_o` is low.
- R2: A write keeps only these bits: the count at bits 23:10, U at bit 6, S at bit 7, M at bit 9, VU at bit 25 and VS at bit 26. Every other bit of the stored word reads zero, including the action bits 5:0, bit 8 and bit 24.
- R3: While the count is zero, retirements leave the word unchanged and never raise `fire_o`. Writing a zero count stops a running countdown without firing.
- R4: With `virt_i` low, a retirement decrements the count by one, visible on the next cycle, when the enable bit for the current level is set (U for 0, S for 1, M for 3). Level 2 never counts.
- R5: With `virt_i` high, only VS (level 1) and VU (level 0) enable counting. The M, S and U bits are ignored, and level 3 never counts.
- R6: A cycle without a retirement, or a retirement in a level whose enable is clear, leaves the count unchanged.
- R7: The retirement that takes the count from 1 to 0 raises `fire_o` for exactly one cycle: the cycle after that retirement, in which the count already reads zero. The count then stays at zero and does not wrap.
- R8: A write whose kept bits differ from the current stored word (live count included) loads the written value and restarts counting from it. A retirement in the same cycle is not counted.
- R9: A write whose kept bits equal the current stored word changes nothing, and a retirement in the same cycle is still counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| retire_i | input | 1 | One instruction retires this cycle |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart runs virtualized |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | XLEN | Control word write data |
| ctrl_rdata_o | output | XLEN | Control word readback with live count |
| count_o | output | CNT_W | Live remaining count |
| fire_o | output | 1 | Single-cycle breakpoint request |

## Verification
Every effect is registered once. A write or an enabled retirement presented in one cycle shows in `ctrl_rdata_o` and `count_o` after the next rising edge, and `fire_o` appears after that same edge, together with the zero count. It drops again one edge later. The bench therefore drives inputs on the falling edge and samples one falling edge later. For the fire pulse it checks the high level at that first sample and the low level one full cycle later. Pulses are also tallied on every falling edge, so a stray or doubled request in the idle-count and zero-write scenarios is caught.

// File: rtl/icnt_pkg.sv
// Package: shared field positions, privilege codes and the mode-enable
// type for the retired-instruction countdown trigger.
package icnt_pkg;

    // Privilege-level codes carried on priv_i
    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_SUPER = 2'd1;
    localparam logic [1:0] LVL_MACH  = 2'd3;

    // Mode-enable bit positions inside the control word
    localparam int BIT_EN_U  = 6;
    localparam int BIT_EN_S  = 7;
    localparam int BIT_EN_M  = 9;
    localparam int BIT_EN_VU = 25;
    localparam int BIT_EN_VS = 26;

    // Stored privilege enables
    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

endpackage

// File: rtl/icnt_wr_filter.sv
// Module: icnt_wr_filter
// Masks an incoming control-word write down to the kept fields and decides
// whether it is a real update (differs from the current stored word).
// Assumes the enable bit positions lie outside the count field.
module icnt_wr_filter
    import icnt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14
) (
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [XLEN-1:0] cur_word_i,
    output logic            load_o,
    output mode_en_t        new_en_o,
    output logic [CNT_W-1:0] new_cnt_o
);

    localparam logic [XLEN-1:0] CNT_MASK = ((XLEN'(1) << CNT_W) - XLEN'(1)) << CNT_LSB;
    localparam logic [XLEN-1:0] EN_MASK  = (XLEN'(1) << BIT_EN_U)  | (XLEN'(1) << BIT_EN_S)
                                         | (XLEN'(1) << BIT_EN_M)  | (XLEN'(1) << BIT_EN_VU)
                                         | (XLEN'(1) << BIT_EN_VS);
    localparam logic [XLEN-1:0] KEEP_MASK = CNT_MASK | EN_MASK;

    logic [XLEN-1:0] masked;

    // Strip every field that is not kept and flag a changed word
    always_comb begin
        masked         = wdata_i & KEEP_MASK;
        load_o         = we_i && (masked != cur_word_i);
        new_cnt_o      = masked[CNT_LSB +: CNT_W];
        new_en_o.u     = masked[BIT_EN_U];
        new_en_o.s     = masked[BIT_EN_S];
        new_en_o.m     = masked[BIT_EN_M];
        new_en_o.vu    = masked[BIT_EN_VU];
        new_en_o.vs    = masked[BIT_EN_VS];
    end

endmodule

// File: rtl/icnt_mode_gate.sv
// Module: icnt_mode_gate
// Decides whether the current privilege level and virtualization state are
// selected by the stored enables. Reserved level 2 is never selected.
module icnt_mode_gate
    import icnt_pkg::*;
(
    input  mode_en_t   en_i,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    output logic       active_o
);

    // Pick the enable bit matching the level, by virtualization state
    always_comb begin
        active_o = 1'b0;
        if (virt_i) begin
            case (priv_i)
                LVL_USER:  active_o = en_i.vu;
                LVL_SUPER: active_o = en_i.vs;
                default:   active_o = 1'b0;
            endcase
        end else begin
            case (priv_i)
                LVL_USER:  active_o = en_i.u;
                LVL_SUPER: active_o = en_i.s;
                LVL_MACH:  active_o = en_i.m;
                default:   active_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/icnt_counter.sv
// Module: icnt_counter
// Holds the enables and the live count. A load wins over a step; a step
// decrements a non-zero count and raises a one-cycle fire on reaching zero.
// Assumes step_i is already qualified by the mode gate.
module icnt_counter
    import icnt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  mode_en_t         new_en_i,
    input  logic [CNT_W-1:0] new_cnt_i,
    input  logic             step_i,
    output mode_en_t         en_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    mode_en_t         en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fire_q;

    // Load, count down and generate the expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (load_i) begin
                en_q  <= new_en_i;
                cnt_q <= new_cnt_i;
            end else if (step_i && (cnt_q != '0)) begin
                cnt_q  <= cnt_q - CNT_ONE;
                fire_q <= (cnt_q == CNT_ONE);
            end
        end
    end

    assign en_o   = en_q;
    assign cnt_o  = cnt_q;
    assign fire_o = fire_q;

endmodule

// File: rtl/icnt_trigger.sv
// Module: icnt_trigger
// Retired-instruction countdown trigger. The count lives inside the control
// word and decrements in place; reaching zero requests a breakpoint once.
// Assumes at most one retirement per cycle and XLEN wide enough for bit 26.
module icnt_trigger
    import icnt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic             ctrl_we_i,
    input  logic [XLEN-1:0]  ctrl_wdata_i,
    output logic [XLEN-1:0]  ctrl_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o
);

    mode_en_t         en_cur;
    mode_en_t         en_new;
    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_new;
    logic             load;
    logic             active;
    logic [XLEN-1:0]  word;

    // Assemble the stored control word from enables and live count
    always_comb begin
        word                   = '0;
        word[CNT_LSB +: CNT_W] = cnt_cur;
        word[BIT_EN_U]         = en_cur.u;
        word[BIT_EN_S]         = en_cur.s;
        word[BIT_EN_M]         = en_cur.m;
        word[BIT_EN_VU]        = en_cur.vu;
        word[BIT_EN_VS]        = en_cur.vs;
    end

    icnt_wr_filter #(
        .XLEN    (XLEN),
        .CNT_LSB (CNT_LSB),
        .CNT_W   (CNT_W)
    ) u_filter (
        .we_i       (ctrl_we_i),
        .wdata_i    (ctrl_wdata_i),
        .cur_word_i (word),
        .load_o     (load),
        .new_en_o   (en_new),
        .new_cnt_o  (cnt_new)
    );

    icnt_mode_gate u_gate (
        .en_i     (en_cur),
        .priv_i   (priv_i),
        .virt_i   (virt_i),
        .active_o (active)
    );

    icnt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .new_en_i  (en_new),
        .new_cnt_i (cnt_new),
        .step_i    (retire_i && active),
        .en_o      (en_cur),
        .cnt_o     (cnt_cur),
        .fire_o    (fire_o)
    );

    assign ctrl_rdata_o = word;
    assign count_o      = cnt_cur;

endmodule

// File: rtl/icnt_trigger_sva.sv
// Module: icnt_trigger_sva
// Property checker for icnt_trigger, attached through bind below.
module icnt_trigger_sva
    import icnt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire_i,
    input logic [1:0]       priv_i,
    input logic             virt_i,
    input logic             ctrl_we_i,
    input logic [XLEN-1:0]  ctrl_rdata_o,
    input logic [CNT_W-1:0] count_o,
    input logic             fire_o
);

    localparam logic [XLEN-1:0] CHK_KEEP =
        (((XLEN'(1) << CNT_W) - XLEN'(1)) << CNT_LSB)
        | (XLEN'(1) << BIT_EN_U) | (XLEN'(1) << BIT_EN_S) | (XLEN'(1) << BIT_EN_M)
        | (XLEN'(1) << BIT_EN_VU) | (XLEN'(1) << BIT_EN_VS);

    // R1: first cycle out of reset shows a clear word and no request
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_rdata_o == '0) && !fire_o);

    // R2: bits outside the kept fields never read as one
    a_r2_clean_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o & ~CHK_KEEP) == '0);

    // R3: an idle count stays idle without a write
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) && !ctrl_we_i |=> (count_o == '0));

    // R4: without a write the count moves by at most one, downward
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1));

    // R5: virtualized machine level never counts
    a_r5_virt_mach_hold: assert property (@(posedge clk) disable iff (!rst_n)
        virt_i && (priv_i == LVL_MACH) && !ctrl_we_i |=> $stable(count_o));

    // R6: no retirement and no write means no change
    a_r6_no_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i && !ctrl_we_i |=> $stable(count_o));

    // R7: a request follows a 1-to-0 step and lasts a single cycle
    a_r7_fire_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (count_o == '0) && ($past(count_o) == CNT_W'(1)) && $past(retire_i));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

bind icnt_trigger icnt_trigger_sva #(
    .XLEN    (XLEN),
    .CNT_LSB (CNT_LSB),
    .CNT_W   (CNT_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_i     (retire_i),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .count_o      (count_o),
    .fire_o       (fire_o)
);

// File: tb/icnt_trigger_test.sv
// Directed bench for icnt_trigger: one task per scenario, each self-checking.
module icnt_trigger_test;

    localparam int XLEN = 32;
    localparam int CW   = 14;

    localparam logic [31:0] EN_U  = 32'h0000_0040;
    localparam logic [31:0] EN_S  = 32'h0000_0080;
    localparam logic [31:0] EN_M  = 32'h0000_0200;
    localparam logic [31:0] EN_VU = 32'h0200_0000;
    localparam logic [31:0] EN_VS = 32'h0400_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            retire_i = 1'b0;
    logic [1:0]      priv_i = 2'd3;
    logic            virt_i = 1'b0;
    logic            ctrl_we_i = 1'b0;
    logic [XLEN-1:0] ctrl_wdata_i = '0;
    logic [XLEN-1:0] ctrl_rdata_o;
    logic [CW-1:0]   count_o;
    logic            fire_o;

    int checks = 0;
    int failures = 0;
    int fires = 0;

    icnt_trigger uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_i     (retire_i),
        .priv_i       (priv_i),
        .virt_i       (virt_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .ctrl_rdata_o (ctrl_rdata_o),
        .count_o      (count_o),
        .fire_o       (fire_o)
    );

    always #2 clk = ~clk;

    // Tally breakpoint requests away from the active edge
    always @(negedge clk) if (rst_n && fire_o) fires++;

    function automatic logic [31:0] mkw(input int cnt, input logic [31:0] en);
        return (32'(cnt) << 10) | en;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        ctrl_we_i = 1'b1; ctrl_wdata_i = w;
        @(negedge clk);
        ctrl_we_i = 1'b0;
    endtask

    task automatic wr_ret(input logic [31:0] w, input logic [1:0] p, input logic v);
        @(negedge clk);
        ctrl_we_i = 1'b1; ctrl_wdata_i = w; retire_i = 1'b1; priv_i = p; virt_i = v;
        @(negedge clk);
        ctrl_we_i = 1'b0; retire_i = 1'b0;
    endtask

    task automatic ret(input int n, input logic [1:0] p, input logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            retire_i = 1'b1; priv_i = p; virt_i = v;
            @(negedge clk);
            retire_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 word after reset", ctrl_rdata_o, 32'h0);
        chk("R1 fire after reset", 32'(fire_o), 32'h0);
    endtask

    task automatic t_mask();
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones write masked", ctrl_rdata_o, 32'h06FF_FEC0);
        chk("R2 count port full", 32'(count_o), 32'h3FFF);
        wr(32'h0100_013F);
        chk("R2 action/pending/hit dropped", ctrl_rdata_o, 32'h0);
    endtask

    task automatic t_zero_idle();
        int f0;
        wr(EN_M);
        f0 = fires;
        ret(3, 2'd3, 1'b0);
        chk("R3 zero count idle", ctrl_rdata_o, EN_M);
        chk("R3 no fire when idle", 32'(fires - f0), 32'd0);
    endtask

    task automatic t_count_and_fire();
        int f0;
        wr(mkw(5, EN_M | EN_U));
        ret(2, 2'd3, 1'b0);
        chk("R4 machine level counts", 32'(count_o), 32'd3);
        ret(1, 2'd0, 1'b0);
        chk("R4 user level counts", 32'(count_o), 32'd2);
        ret(1, 2'd2, 1'b0);
        chk("R4 reserved level holds", 32'(count_o), 32'd2);
        ret(1, 2'd1, 1'b0);
        chk("R6 disabled level holds", 32'(count_o), 32'd2);
        repeat (3) @(negedge clk);
        chk("R6 no retire holds", 32'(count_o), 32'd2);
        f0 = fires;
        ret(1, 2'd3, 1'b0);
        chk("R7 count at one", 32'(count_o), 32'd1);
        chk("R7 no early fire", 32'(fire_o), 32'd0);
        ret(1, 2'd3, 1'b0);
        chk("R7 count reaches zero", 32'(count_o), 32'd0);
        chk("R7 fire high", 32'(fire_o), 32'd1);
        @(negedge clk);
        chk("R7 fire one cycle", 32'(fire_o), 32'd0);
        ret(3, 2'd3, 1'b0);
        chk("R7 no wrap", ctrl_rdata_o, EN_M | EN_U);
        chk("R7 single pulse total", 32'(fires - f0), 32'd1);
    endtask

    task automatic t_virt();
        wr(mkw(4, EN_VS));
        ret(1, 2'd1, 1'b1);
        chk("R5 VS counts", 32'(count_o), 32'd3);
        ret(1, 2'd0, 1'b1);
        chk("R5 VU clear holds", 32'(count_o), 32'd3);
        wr(mkw(4, EN_VU | EN_M | EN_S | EN_U));
        ret(1, 2'd3, 1'b1);
        chk("R5 virt machine holds", 32'(count_o), 32'd4);
        ret(1, 2'd1, 1'b1);
        chk("R5 S bit ignored when virt", 32'(count_o), 32'd4);
        ret(1, 2'd0, 1'b1);
        chk("R5 VU counts", 32'(count_o), 32'd3);
        ret(1, 2'd0, 1'b0);
        chk("R4 U counts when not virt", 32'(count_o), 32'd2);
    endtask

    task automatic t_restart();
        wr(mkw(10, EN_M));
        ret(3, 2'd3, 1'b0);
        chk("R8 counted to seven", 32'(count_o), 32'd7);
        wr(mkw(10, EN_M));
        chk("R8 rewrite restarts", ctrl_rdata_o, mkw(10, EN_M));
        wr_ret(mkw(20, EN_M), 2'd3, 1'b0);
        chk("R8 load wins over retire", 32'(count_o), 32'd20);
    endtask

    task automatic t_equal();
        wr_ret(mkw(20, EN_M), 2'd3, 1'b0);
        chk("R9 equal write still counts", 32'(count_o), 32'd19);
        wr(mkw(19, EN_M) | 32'h0000_0013);
        chk("R9 equal write no change", ctrl_rdata_o, mkw(19, EN_M));
    endtask

    task automatic t_zero_write();
        int f0;
        wr(mkw(2, EN_M));
        ret(1, 2'd3, 1'b0);
        f0 = fires;
        wr(EN_M);
        ret(2, 2'd3, 1'b0);
        chk("R3 zero write stops", ctrl_rdata_o, EN_M);
        chk("R3 zero write no fire", 32'(fires - f0), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_zero_idle();
        t_count_and_fire();
        t_virt();
        t_restart();
        t_equal();
        t_zero_write();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule